// File: doc/BRIEF.md
# Protected GPIO Pad Configuration Register Bank

This block holds the pad settings of one GPIO port of eight pins. For every pin it stores an alternate-function enable, a digital-input enable, a pull-up select, a pull-down select and a 4-bit peripheral mux code. It drives these straight to the pad logic from flops. Software reaches the settings over a simple synchronous register bus that has a byte address, a write strobe, 32-bit write data and registered 32-bit read data. Read data appears on the clock edge after the address is presented.

The pull-up and pull-down selections of a pin are never both active. Raising either one through a write drops the other one in that same write. Five pins are protected: four debug-port pins (0 to 3) and one non-maskable-interrupt pin (7). Writes to the alternate-function, digital-enable, pull-up and pull-down bits of a protected pin are dropped without any error unless two conditions hold: the port has been unlocked with a 32-bit key, and the commit bit of that pin is set. The mux code is never protected. A synchronous reset returns every setting to its default.

Top module: `gpio_padcfg`

## Requirements
- R1: After reset the stored settings are as follows. Pins 0..3: alt-function=1, digital-enable=1, pull-up=1, pull-down=0, mux code 1. Pins 4 and 5: mux code 2. Pin 6: mux code 3. Pin 7 and all other settings: 0. The lock reads 1 and the commit register reads 0x70.
- R2: The pull-down register is at byte offset 0x514. Bits 7:0 (bit n = pin n) are read/write and bits 31:8 always read as zero. A permitted write changes the pad output on the first clock edge after the bus write.
- R3: A permitted write of 1 to a pull-down bit (offset 0x514) clears the matching pull-up bit. A permitted write of 1 to a pull-up bit (offset 0x510) clears the matching pull-down bit. After any write, no pin has both bits set.
- R4: For the unprotected pins (4, 5, 6), writes to alt-function (0x420), pull-up, pull-down and digital-enable (0x51C) always take effect.
- R5: For the protected pins (0..3 and 7), a write to the alt-function, pull-up, pull-down or digital-enable bit takes effect only while the port is unlocked and that pin's commit bit is 1. Otherwise the stored bit keeps its value.
- R6: Writing 0x1ACCE55E to the lock register (0x520) unlocks the port, and writing any other value relocks it. A read of the lock register returns 1 when locked and 0 when unlocked.
- R7: The commit register (0x524, bit n = pin n) takes writes only while the port is unlocked. A write while locked leaves it unchanged.
- R8: The mux register (0x52C) holds pin n's code in bits 4n+3:4n. It is written regardless of lock and commit.
- R9: Read data is registered and reflects the address of the previous cycle. Any offset not listed above, including any address that is not word-aligned, reads as zero.
- R10: Asserting reset in the middle of operation returns every setting, the lock and the commit register to the values in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_afsel | output | 8 | Alternate-function enable per pin |
| pad_den | output | 8 | Digital enable per pin |
| pad_pu | output | 8 | Pull-up select per pin |
| pad_pd | output | 8 | Pull-down select per pin |
| pad_mux | output | 32 | 4-bit mux code per pin |

## Verification
Assertions check four rules on every cycle. No pin holds both pull selections. A pin whose write permission is off keeps its four protected bits across the edge. The commit register does not move while the port is locked. The reserved pull-down bits and the unmapped offsets read as zero. Other behaviour can only be shown by the bench's scenarios: the exact reset defaults, the key comparison, the one-cycle read latency, and the combined outcome of lock, commit pattern and write data. For that, the bench sweeps all 256 write values and all 256 commit patterns against its own model of the requirements.

// File: rtl/gpio_padcfg_pkg.sv
package gpio_padcfg_pkg;

  localparam logic [11:0] OFS_AFSEL  = 12'h420;
  localparam logic [11:0] OFS_PULLUP = 12'h510;
  localparam logic [11:0] OFS_PULLDN = 12'h514;
  localparam logic [11:0] OFS_DIGEN  = 12'h51C;
  localparam logic [11:0] OFS_LOCK   = 12'h520;
  localparam logic [11:0] OFS_COMMIT = 12'h524;
  localparam logic [11:0] OFS_MUX    = 12'h52C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_AF, SEL_PU, SEL_PD, SEL_DEN, SEL_LOCK, SEL_COMMIT, SEL_MUX
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [11:0] a);
    case (a)
      OFS_AFSEL:  return SEL_AF;
      OFS_PULLUP: return SEL_PU;
      OFS_PULLDN: return SEL_PD;
      OFS_DIGEN:  return SEL_DEN;
      OFS_LOCK:   return SEL_LOCK;
      OFS_COMMIT: return SEL_COMMIT;
      OFS_MUX:    return SEL_MUX;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl #(
  parameter int unsigned   NP   = 8,
  parameter logic [NP-1:0] PROT = 8'h8F,
  parameter logic [31:0]   KEY  = 32'h1ACCE55E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lock,
  input  logic          wr_commit,
  input  logic [31:0]   wdata,
  output logic          unlocked,
  output logic [NP-1:0] commit,
  output logic [NP-1:0] allow
);

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      commit   <= ~PROT;
    end else begin
      if (wr_lock) unlocked <= (wdata == KEY);
      if (wr_commit && unlocked) commit <= wdata[NP-1:0];
    end
  end

  // per-pin write permission for the protected fields
  assign allow = ~PROT | ({NP{unlocked}} & commit);

  AST_COMMIT_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && !unlocked) |=> $stable(commit)); // R7
  AST_LOCK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_lock |=> $stable(unlocked)); // R6

endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg #(
  parameter int unsigned     MUXW    = 4,
  parameter logic            RST_AF  = 1'b0,
  parameter logic            RST_DEN = 1'b0,
  parameter logic            RST_PU  = 1'b0,
  parameter logic            RST_PD  = 1'b0,
  parameter logic [MUXW-1:0] RST_MUX = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            allow,
  input  logic            wr_af,
  input  logic            wr_den,
  input  logic            wr_pu,
  input  logic            wr_pd,
  input  logic            wr_mux,
  input  logic            bit_in,
  input  logic [MUXW-1:0] mux_in,
  output logic            af,
  output logic            den,
  output logic            pu,
  output logic            pd,
  output logic [MUXW-1:0] mux
);

  always_ff @(posedge clk) begin
    if (rst) begin
      af  <= RST_AF;
      den <= RST_DEN;
      pu  <= RST_PU;
      pd  <= RST_PD;
      mux <= RST_MUX;
    end else begin
      if (wr_af  && allow) af  <= bit_in;
      if (wr_den && allow) den <= bit_in;
      if (wr_pu && allow) begin
        pu <= bit_in;
        if (bit_in) pd <= 1'b0;
      end
      if (wr_pd && allow) begin
        pd <= bit_in;
        if (bit_in) pu <= 1'b0;
      end
      if (wr_mux) mux <= mux_in;
    end
  end

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pu && pd)); // R3
  AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !allow |=> $stable({af, den, pu, pd})); // R5
  AST_MUX_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_mux |=> $stable(mux)); // R8

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_padcfg_pkg::*;
#(
  parameter int unsigned NP   = 8,
  parameter int unsigned MUXW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  reg_sel_e           sel,
  input  logic [NP-1:0]      af,
  input  logic [NP-1:0]      den,
  input  logic [NP-1:0]      pu,
  input  logic [NP-1:0]      pd,
  input  logic               unlocked,
  input  logic [NP-1:0]      commit,
  input  logic [NP*MUXW-1:0] mux,
  output logic [31:0]        rdata
);

  logic [31:0] rd_next;

  always_comb begin
    case (sel)
      SEL_AF:     rd_next = 32'(af);
      SEL_PU:     rd_next = 32'(pu);
      SEL_PD:     rd_next = 32'(pd);
      SEL_DEN:    rd_next = 32'(den);
      SEL_LOCK:   rd_next = {31'b0, ~unlocked};
      SEL_COMMIT: rd_next = 32'(commit);
      SEL_MUX:    rd_next = 32'(mux);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == SEL_NONE) |-> (rdata == 32'h0)); // R9
  AST_PD_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == SEL_PD) |-> (rdata[31:NP] == '0)); // R2

endmodule

// File: rtl/gpio_padcfg.sv
module gpio_padcfg
  import gpio_padcfg_pkg::*;
#(
  parameter int unsigned          NP        = 8,
  parameter int unsigned          MUXW      = 4,
  parameter logic [NP-1:0]        PROT      = 8'h8F,
  parameter logic [31:0]          KEY       = 32'h1ACCE55E,
  parameter logic [NP-1:0]        RST_AF    = 8'h0F,
  parameter logic [NP-1:0]        RST_DEN   = 8'h0F,
  parameter logic [NP-1:0]        RST_PU    = 8'h0F,
  parameter logic [NP-1:0]        RST_PD    = 8'h00,
  parameter logic [NP*MUXW-1:0]   RST_MUX   = 32'h03221111
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [11:0]        bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NP-1:0]      pad_afsel,
  output logic [NP-1:0]      pad_den,
  output logic [NP-1:0]      pad_pu,
  output logic [NP-1:0]      pad_pd,
  output logic [NP*MUXW-1:0] pad_mux
);

  reg_sel_e      sel;
  logic          unlocked;
  logic [NP-1:0] commit;
  logic [NP-1:0] allow;

  assign sel = decode_sel(bus_addr);

  gpio_lock_ctrl #(.NP(NP), .PROT(PROT), .KEY(KEY)) i_lock (
    .clk       (clk),
    .rst       (rst),
    .wr_lock   (bus_we && sel == SEL_LOCK),
    .wr_commit (bus_we && sel == SEL_COMMIT),
    .wdata     (bus_wdata),
    .unlocked  (unlocked),
    .commit    (commit),
    .allow     (allow)
  );

  for (genvar i = 0; i < NP; i++) begin : g_pin
    gpio_pin_cfg #(
      .MUXW    (MUXW),
      .RST_AF  (RST_AF[i]),
      .RST_DEN (RST_DEN[i]),
      .RST_PU  (RST_PU[i]),
      .RST_PD  (RST_PD[i]),
      .RST_MUX (RST_MUX[i*MUXW +: MUXW])
    ) i_cfg (
      .clk    (clk),
      .rst    (rst),
      .allow  (allow[i]),
      .wr_af  (bus_we && sel == SEL_AF),
      .wr_den (bus_we && sel == SEL_DEN),
      .wr_pu  (bus_we && sel == SEL_PU),
      .wr_pd  (bus_we && sel == SEL_PD),
      .wr_mux (bus_we && sel == SEL_MUX),
      .bit_in (bus_wdata[i]),
      .mux_in (bus_wdata[i*MUXW +: MUXW]),
      .af     (pad_afsel[i]),
      .den    (pad_den[i]),
      .pu     (pad_pu[i]),
      .pd     (pad_pd[i]),
      .mux    (pad_mux[i*MUXW +: MUXW])
    );
  end

  gpio_rd_mux #(.NP(NP), .MUXW(MUXW)) i_rd (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .af       (pad_afsel),
    .den      (pad_den),
    .pu       (pad_pu),
    .pd       (pad_pd),
    .unlocked (unlocked),
    .commit   (commit),
    .mux      (pad_mux),
    .rdata    (bus_rdata)
  );

endmodule

// File: tb/test_gpio_padcfg.sv
module test_gpio_padcfg;
  import gpio_padcfg_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  PROT = 8'h8F;
  localparam logic [31:0] KEY  = 32'h1ACCE55E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_afsel, pad_den, pad_pu, pad_pd;
  logic [31:0] pad_mux;

  int nchecks = 0;
  int nerrors = 0;
  bit done = 1'b0;

  logic [7:0]  m_af, m_den, m_pu, m_pd, m_cr;
  logic [31:0] m_mux;
  logic        m_unl;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_padcfg i_gpio_padcfg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_afsel(pad_afsel),
    .pad_den(pad_den), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_mux(pad_mux)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_defaults();
    m_af = 8'h0F; m_den = 8'h0F; m_pu = 8'h0F; m_pd = 8'h00;
    m_mux = 32'h03221111; m_cr = 8'h70; m_unl = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [7:0] wm;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    wm = ~PROT | (m_unl ? m_cr : 8'h00);
    case (a)
      OFS_AFSEL:  m_af  = (m_af  & ~wm) | (d[7:0] & wm);
      OFS_DIGEN:  m_den = (m_den & ~wm) | (d[7:0] & wm);
      OFS_PULLUP: begin
        m_pu = (m_pu & ~wm) | (d[7:0] & wm);
        m_pd = m_pd & ~(d[7:0] & wm);
      end
      OFS_PULLDN: begin
        m_pd = (m_pd & ~wm) | (d[7:0] & wm);
        m_pu = m_pu & ~(d[7:0] & wm);
      end
      OFS_LOCK:   m_unl = (d == KEY);
      OFS_COMMIT: if (m_unl) m_cr = d[7:0];
      OFS_MUX:    m_mux = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, $sformatf("read %h", a), v, exp);
  endtask

  task automatic chk_pads(input string req);
    chk(req, "pad_afsel", 32'(pad_afsel), 32'(m_af));
    chk(req, "pad_den",   32'(pad_den),   32'(m_den));
    chk(req, "pad_pu",    32'(pad_pu),    32'(m_pu));
    chk(req, "pad_pd",    32'(pad_pd),    32'(m_pd));
    chk(req, "pad_mux",   pad_mux,        m_mux);
  endtask

  task automatic chk_defaults(input string req);
    chk(req, "default afsel", 32'(pad_afsel), 32'h0F);
    chk(req, "default den",   32'(pad_den),   32'h0F);
    chk(req, "default pu",    32'(pad_pu),    32'h0F);
    chk(req, "default pd",    32'(pad_pd),    32'h00);
    chk(req, "default mux",   pad_mux,        32'h03221111);
    chk_reg(req, OFS_LOCK,   32'h1);
    chk_reg(req, OFS_COMMIT, 32'h70);
    chk_reg(req, OFS_AFSEL,  32'h0F);
    chk_reg(req, OFS_MUX,    32'h03221111);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bus_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_defaults();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    chk_defaults("R1");

    // R2 R3 R4 R5: locked sweep of pull registers, protected pins must hold
    for (int i = 0; i < 256; i++) begin
      wr(OFS_PULLUP, 32'(i));
      wr(OFS_PULLDN, 32'hFFFF_FF00 | 32'(i ^ 8'hA5));
      chk("R2", "pd after write", 32'(pad_pd), 32'(m_pd));
      rd(OFS_PULLDN, v);
      chk("R2", "pd read", v, 32'(m_pd));
      rd(OFS_PULLUP, v);
      chk("R3", "pu read", v, 32'(m_pu));
      chk("R3", "pu&pd overlap", 32'(pad_pu & pad_pd), 32'h0);
      chk("R5", "locked protected pu", 32'(pad_pu & PROT), 32'h0F);
    end
    // R4 R5: locked sweep of alt-function and digital enable
    for (int i = 0; i < 256; i++) begin
      wr(OFS_AFSEL, 32'(i));
      wr(OFS_DIGEN, 32'(~i));
      chk("R4", "unprotected afsel", 32'(pad_afsel & ~PROT), 32'(i & ~PROT));
      chk("R5", "locked protected afsel", 32'(pad_afsel & PROT), 32'h0F);
      chk_pads("R5");
    end

    // R7: commit write while locked is ignored
    wr(OFS_COMMIT, 32'hFF);
    chk_reg("R7", OFS_COMMIT, 32'h70);
    // R6: wrong key stays locked, right key unlocks
    wr(OFS_LOCK, KEY ^ 32'h1);
    chk_reg("R6", OFS_LOCK, 32'h1);
    wr(OFS_LOCK, KEY);
    chk_reg("R6", OFS_LOCK, 32'h0);
    // R5 R7: sweep every commit pattern while unlocked
    for (int c = 0; c < 256; c++) begin
      wr(OFS_COMMIT, 32'(c));
      chk_reg("R7", OFS_COMMIT, 32'(c));
      wr(OFS_AFSEL, 32'(~m_af));
      wr(OFS_PULLDN, 32'(c ^ 8'h3C));
      wr(OFS_PULLUP, 32'(c * 7));
      chk_pads("R5");
      chk("R3", "pu&pd overlap", 32'(pad_pu & pad_pd), 32'h0);
    end
    // R3: both set for all pins, the written register wins
    wr(OFS_COMMIT, 32'hFF);
    wr(OFS_PULLUP, 32'hFF);
    wr(OFS_PULLDN, 32'hFF);
    chk("R3", "pd wins", 32'(pad_pd), 32'hFF);
    chk("R3", "pu cleared", 32'(pad_pu), 32'h00);
    wr(OFS_PULLUP, 32'h0F);
    chk("R3", "pu wins", 32'(pad_pu), 32'h0F);
    chk("R3", "pd cleared", 32'(pad_pd), 32'hF0);
    // R6: any other value relocks, protected pins hold again
    wr(OFS_LOCK, 32'h0);
    chk_reg("R6", OFS_LOCK, 32'h1);
    wr(OFS_AFSEL, 32'(~m_af));
    chk_pads("R5");

    // R8: mux register written regardless of lock
    for (int i = 0; i < 32; i++) begin
      wr(OFS_MUX, 32'h9E3779B9 * 32'(i + 1));
      chk("R8", "pad_mux", pad_mux, 32'h9E3779B9 * 32'(i + 1));
      rd(OFS_MUX, v);
      chk("R8", "mux read", v, m_mux);
    end

    // R9: unmapped and misaligned offsets read zero
    chk_reg("R9", 12'h000, 32'h0);
    chk_reg("R9", 12'h516, 32'h0);
    chk_reg("R9", 12'h518, 32'h0);
    chk_reg("R9", 12'h528, 32'h0);
    chk_reg("R9", 12'hFFC, 32'h0);
    chk_reg("R9", 12'h421, 32'h0);
    // R9: read latency of one edge
    @(negedge clk); bus_addr = OFS_DIGEN;
    @(posedge clk); #1;
    chk("R9", "rdata after one edge", bus_rdata, 32'(m_den));

    // R10: reset mid-run restores defaults
    wr(OFS_LOCK, KEY);
    wr(OFS_COMMIT, 32'h0);
    do_reset();
    chk_defaults("R10");
    chk_reg("R10", OFS_PULLDN, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

endmodule